// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

An eight-line input port that turns pin activity into interrupts under the control of a small byte-wide register bus. Every register bit maps to the line with the same index. For each line, software picks whether the line reacts to a level or to an edge, which polarity counts as active, whether the line may interrupt at all, and whether its input is filtered by a debounce stage first.

Pins are asynchronous. Each pin passes through a two-flop synchroniser. A line can then go through a counter-based debounce filter, and after that it is compared against its trigger setting. Edge-sensed lines hold a sticky pending flag. Software clears that flag by writing a mask with ones in the line positions to the acknowledge address. Level-sensed lines follow the qualified input and need no acknowledge. The block drives one interrupt output per line and a combined output that is the OR of all of them. The per-line vector can also be read back as a status register.

The bus has no handshake. A write takes effect at the clock edge on which `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the sense-mode, polarity, enable and debounce registers are all zero, every pending flag is clear, and `line_irq`, `irq_out` and the status read are all 0.
- R2: Address map: 0 = sense mode, 1 = polarity, 2 = enable, 3 = debounce enable. Each of these reads back the last value written. Address 4 (acknowledge) reads 0. Address 5 reads the per-line interrupt vector. Addresses 6 and 7 read 0 and ignore writes.
- R3: A line whose sense-mode bit is 0 is level sensed. Its interrupt is high when the line is enabled and its qualified level equals its polarity bit (1 = active high, 0 = active low). With debounce off, a pin change reaches the output after two rising clock edges.
- R4: A line whose sense-mode bit is 1 is edge sensed. Polarity bit 1 selects rising edges and 0 selects falling edges. A matching edge on an enabled line sets a pending flag, which shows on the output three rising edges after the pin changes and stays set after the pin returns.
- R5: A write to address 4 clears the pending flag of each line whose data bit is 1. Lines whose data bit is 0 keep their flags.
- R6: If a new matching edge and an acknowledge for the same line occur on the same clock edge, the pending flag stays set.
- R7: A line whose enable bit is 0 drives 0 on its interrupt. Edges that arrive, and changes to the sense-mode or polarity registers made, while the line is disabled leave no pending flag behind.
- R8: `irq_out` is the OR of `line_irq`, and a read of address 5 returns `line_irq`.
- R9: With its debounce bit at 1, a line's new synchronised level is accepted only after it has differed from the held level for DEB_CYCLES consecutive cycles (default 4). A pulse that lasts fewer cycles than that is ignored.
- R10: While a line is in level mode its pending flag is held clear, so returning the line to edge mode shows no stale interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | LINES | Asynchronous pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | LINES | Write data, bit i for line i |
| bus_rdata | output | LINES | Read data for `bus_addr` |
| line_irq | output | LINES | Per-line interrupt outputs |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench runs the main function under several distinct input patterns, and each pattern separates a different class of error:
- Level sensing with mixed polarities across the two nibbles separates a polarity inversion from a sense-mode decode error.
- Rising edges on the even lines followed by falling edges on the odd lines show that edge direction follows the polarity bits and that flags stay sticky.
- Partial acknowledge masks, including an all-zero mask, separate per-bit clearing from whole-register clearing.
- An acknowledge timed to land on the same edge as a new edge exposes a clear-over-set priority error.
- Pin and type toggling while the lines are disabled exposes spurious latching.
- A three-cycle glitch next to a sustained change, on a debounced line and an unfiltered line, tells an off-by-one in the debounce count from a missing filter.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_POL  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_EN   = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_DEB  = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_ACK  = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 3'd5;

  // Level qualifies when it matches the selected polarity.
  function automatic logic level_active(logic lvl, logic pol);
    return lvl == pol;
  endfunction

  // Edge qualifies when its direction matches polarity (1 rising, 0 falling).
  function automatic logic edge_active(logic cur, logic prv, logic pol);
    return pol ? (cur & ~prv) : (~cur & prv);
  endfunction

  // Debounce window has been fully observed.
  function automatic logic deb_expired(int unsigned cnt, int unsigned last);
    return cnt >= last;
  endfunction

endpackage

// File: rtl/gpio_line_filter.sv
module gpio_line_filter #(
  parameter int unsigned DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic deb_en,
  output logic lvl_out
);
  import gpio_irq_pkg::*;

  localparam int unsigned CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam int unsigned CNT_LAST = DEB_CYCLES - 1;

  logic             sync_a, sync_b, held_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differs, accept;

  assign differs = sync_b ^ held_q;
  assign accept  = deb_expired(32'(cnt_q), CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_a <= pin_async;
      sync_b <= sync_a;
      if (!deb_en) begin
        held_q <= sync_b;
        cnt_q  <= '0;
      end else if (!differs) begin
        cnt_q  <= '0;
      end else if (accept) begin
        held_q <= sync_b;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_out = deb_en ? held_q : sync_b;

  AST_DEB_HOLD_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_en && differs && !accept) |=> $stable(held_q)); // R9
  AST_DEB_HOLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_en && !differs) |=> $stable(held_q)); // R9
  AST_DEB_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_en && differs && accept) |=> (held_q != $past(held_q))); // R9

endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic edge_mode,
  input  logic pol,
  input  logic line_en,
  input  logic ack_clr,
  output logic irq
);
  import gpio_irq_pkg::*;

  logic prev_q, pend_q;
  logic edge_hit, pend_set;

  assign edge_hit = edge_active(lvl, prev_q, pol);
  assign pend_set = line_en & edge_mode & edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (!edge_mode)    pend_q <= 1'b0;
      else if (pend_set) pend_q <= 1'b1;
      else if (ack_clr)  pend_q <= 1'b0;
    end
  end

  assign irq = line_en & (edge_mode ? pend_q : level_active(lvl, pol));

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set |=> pend_q); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pend_q && !ack_clr) |=> pend_q); // R4
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !pend_set) |=> !pend_q); // R5
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set && ack_clr) |=> pend_q); // R6
  AST_OFF_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_en && !pend_q) |=> !pend_q); // R7
  AST_LEVEL_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> !pend_q); // R10

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
  parameter int unsigned LINES = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [gpio_irq_pkg::REG_ADDR_W-1:0]   addr,
  input  logic [LINES-1:0]                      wdata,
  input  logic [LINES-1:0]                      status,
  output logic [LINES-1:0]                      mode_q,
  output logic [LINES-1:0]                      pol_q,
  output logic [LINES-1:0]                      en_q,
  output logic [LINES-1:0]                      deb_q,
  output logic [LINES-1:0]                      ack_mask,
  output logic [LINES-1:0]                      rdata
);
  import gpio_irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      deb_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_MODE: mode_q <= wdata;
        ADDR_POL:  pol_q  <= wdata;
        ADDR_EN:   en_q   <= wdata;
        ADDR_DEB:  deb_q  <= wdata;
        default:   ;
      endcase
    end
  end

  assign ack_mask = (wr_en && addr == ADDR_ACK) ? wdata : '0;

  always_comb begin
    case (addr)
      ADDR_MODE: rdata = mode_q;
      ADDR_POL:  rdata = pol_q;
      ADDR_EN:   rdata = en_q;
      ADDR_DEB:  rdata = deb_q;
      ADDR_STAT: rdata = status;
      default:   rdata = '0;
    endcase
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mode_q) && $stable(pol_q) && $stable(en_q) && $stable(deb_q))); // R2

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int unsigned LINES      = 8,
  parameter int unsigned DEB_CYCLES = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [LINES-1:0]                    pin_in,
  input  logic                                bus_wr,
  input  logic [gpio_irq_pkg::REG_ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]                    bus_wdata,
  output logic [LINES-1:0]                    bus_rdata,
  output logic [LINES-1:0]                    line_irq,
  output logic                                irq_out
);

  logic [LINES-1:0] mode_q, pol_q, en_q, deb_q, ack_mask;
  logic [LINES-1:0] qual_lvl;

  gpio_irq_regs #(.LINES(LINES)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .status   (line_irq),
    .mode_q   (mode_q),
    .pol_q    (pol_q),
    .en_q     (en_q),
    .deb_q    (deb_q),
    .ack_mask (ack_mask),
    .rdata    (bus_rdata)
  );

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    gpio_line_filter #(.DEB_CYCLES(DEB_CYCLES)) filt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (pin_in[gi]),
      .deb_en    (deb_q[gi]),
      .lvl_out   (qual_lvl[gi])
    );
    gpio_line_detect det_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl       (qual_lvl[gi]),
      .edge_mode (mode_q[gi]),
      .pol       (pol_q[gi]),
      .line_en   (en_q[gi]),
      .ack_clr   (ack_mask[gi]),
      .irq       (line_irq[gi])
    );
  end

  assign irq_out = |line_irq;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (line_irq & ~en_q) == '0); // R7
  AST_COMBINED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (line_irq != '0)); // R8

endmodule

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/100ps
module gpio_irq_port_tb_top;
  localparam int DEB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, line_irq;
  logic       irq_out;

  always #2.5 clk = ~clk;

  gpio_irq_port #(.LINES(8), .DEB_CYCLES(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_irq(line_irq), .irq_out(irq_out)
  );

  int checks = 0;
  int bad = 0;
  bit done = 0;

  // Behavioural reference state
  bit [7:0] m_mode, m_pol, m_en, m_deb, m_pend, m_prev, m_s1, m_s2, m_hold;
  int       m_cnt [8];

  function automatic bit [7:0] m_filt();
    bit [7:0] f;
    for (int i = 0; i < 8; i++) f[i] = m_deb[i] ? m_hold[i] : m_s2[i];
    return f;
  endfunction

  function automatic bit [7:0] m_irq();
    bit [7:0] f, r;
    f = m_filt();
    for (int i = 0; i < 8; i++)
      r[i] = m_en[i] && (m_mode[i] ? m_pend[i] : (f[i] == m_pol[i]));
    return r;
  endfunction

  function automatic bit [7:0] m_read(bit [2:0] a);
    case (a)
      3'd0: return m_mode;
      3'd1: return m_pol;
      3'd2: return m_en;
      3'd3: return m_deb;
      3'd5: return m_irq();
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pol = 0; m_en = 0; m_deb = 0; m_pend = 0;
      m_prev = 0; m_s1 = 0; m_s2 = 0; m_hold = 0;
      for (int i = 0; i < 8; i++) m_cnt[i] = 0;
    end else begin
      bit [7:0] f, ack;
      bit hit;
      f = m_filt();
      ack = (bus_wr && bus_addr == 3'd4) ? bus_wdata : 8'h00;
      for (int i = 0; i < 8; i++) begin
        hit = m_pol[i] ? (f[i] && !m_prev[i]) : (!f[i] && m_prev[i]);
        if (!m_mode[i])          m_pend[i] = 0;
        else if (m_en[i] && hit) m_pend[i] = 1;
        else if (ack[i])         m_pend[i] = 0;
        if (!m_deb[i]) begin
          m_hold[i] = m_s2[i]; m_cnt[i] = 0;
        end else if (m_s2[i] == m_hold[i]) begin
          m_cnt[i] = 0;
        end else if (m_cnt[i] == DEB - 1) begin
          m_hold[i] = m_s2[i]; m_cnt[i] = 0;
        end else begin
          m_cnt[i]++;
        end
      end
      m_prev = f;
      m_s2 = m_s1;
      m_s1 = pins;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_mode = bus_wdata;
          3'd1: m_pol  = bus_wdata;
          3'd2: m_en   = bus_wdata;
          3'd3: m_deb  = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk("R3/R4 per-clock line_irq", line_irq, m_irq());
      chk("R8 per-clock irq_out", {7'd0, irq_out}, {7'd0, |m_irq()});
      chk("R2 per-clock rdata", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [7:0] exp);
    @(negedge clk); bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic setpins(logic [7:0] v);
    @(negedge clk); pins = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic now_irq(string tag, logic [7:0] exp);
    #1; chk(tag, line_irq, exp);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    now_irq("R1 reset line_irq", 8'h00);
    chk("R1 reset irq_out", {7'd0, irq_out}, 8'h00);
    for (int a = 0; a < 6; a++) rd("R1 reset register", 3'(a), 8'h00);

    // R2 register access
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd3, 8'h0F); wr(3'd6, 8'hFF);
    rd("R2 mode readback", 3'd0, 8'hA5);
    rd("R2 polarity readback", 3'd1, 8'h3C);
    rd("R2 debounce readback", 3'd3, 8'h0F);
    rd("R2 enable untouched", 3'd2, 8'h00);
    rd("R2 ack reads zero", 3'd4, 8'h00);
    rd("R2 unused 6", 3'd6, 8'h00);
    rd("R2 unused 7", 3'd7, 8'h00);
    wr(3'd3, 8'h00); wr(3'd0, 8'h00);

    // R3 level sensing, mixed polarity
    wr(3'd1, 8'h0F); wr(3'd2, 8'hFF);
    now_irq("R3 level idle", 8'hF0);
    setpins(8'h0F);
    now_irq("R3 level before sync", 8'hF0);
    idle(1); now_irq("R3 level after one edge", 8'hF0);
    idle(1); now_irq("R3 level after two edges", 8'hFF);
    setpins(8'hF0); idle(2); now_irq("R3 level inverted", 8'h00);

    // R7 enable gating
    setpins(8'h00); idle(2); now_irq("R7 pre-gate", 8'hF0);
    wr(3'd2, 8'h0F); now_irq("R7 upper lines gated", 8'h00);
    rd("R8 status gated", 3'd5, 8'h00);

    // R7 no spurious latch while disabled
    wr(3'd2, 8'h00); wr(3'd0, 8'hFF); wr(3'd1, 8'h55);
    wr(3'd1, 8'hAA); wr(3'd1, 8'h55);
    setpins(8'hFF); idle(3); setpins(8'h00); idle(3);
    wr(3'd2, 8'hFF); now_irq("R7 nothing latched while off", 8'h00);

    // R4 edge sensing
    setpins(8'hFF);
    idle(2); now_irq("R4 edge not yet latched", 8'h00);
    idle(1); now_irq("R4 rising on even lines", 8'h55);
    chk("R8 combined high", {7'd0, irq_out}, 8'h01);
    setpins(8'h00); idle(3); now_irq("R4 falling on odd lines", 8'hFF);
    idle(5); now_irq("R4 sticky", 8'hFF);

    // R5 acknowledge
    wr(3'd4, 8'h0F); now_irq("R5 low nibble cleared", 8'hF0);
    wr(3'd4, 8'h00); now_irq("R5 zero mask no effect", 8'hF0);
    wr(3'd4, 8'hF0); now_irq("R5 all cleared", 8'h00);

    // R6 set beats ack on same edge
    setpins(8'h01); idle(3); now_irq("R6 setup pending", 8'h01);
    setpins(8'h00); idle(3); now_irq("R6 falling ignored", 8'h01);
    @(negedge clk); pins = 8'h01;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h01;
    @(negedge clk); bus_wr = 1'b0;
    now_irq("R6 pending survives ack", 8'h01);
    wr(3'd4, 8'h01); now_irq("R5 plain ack clears", 8'h00);

    // R10 level mode clears pending
    setpins(8'h00); idle(3); setpins(8'h01); idle(3);
    now_irq("R10 setup pending", 8'h01);
    wr(3'd0, 8'hFE); now_irq("R10 line0 level active", 8'h01);
    idle(1);
    wr(3'd0, 8'hFF); now_irq("R10 no stale pending", 8'h00);

    // R9 debounce on line 0, line 1 unfiltered
    wr(3'd2, 8'h00); wr(3'd0, 8'h00); wr(3'd1, 8'hFF); wr(3'd3, 8'h01);
    setpins(8'h00); idle(8);
    wr(3'd2, 8'hFF); now_irq("R9 quiet start", 8'h00);
    setpins(8'h03); idle(2);
    now_irq("R9 glitch seen on plain line only", 8'h02);
    @(negedge clk); pins = 8'h00;
    idle(8); now_irq("R9 short pulse rejected", 8'h00);
    setpins(8'h01);
    idle(5); now_irq("R9 not yet accepted", 8'h00);
    idle(1); now_irq("R9 accepted after window", 8'h01);
    rd("R8 status equals line_irq", 3'd5, 8'h01);
    chk("R8 combined follows", {7'd0, irq_out}, 8'h01);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule